// File: doc/BRIEF.md
# Minimal 8-bit Accumulator Processor Core

This block is a very small sequential processor. It keeps a 16-bit program counter and one 8-bit working register, fetches single-byte opcodes from a byte-wide memory with a 16-bit address, and executes them one at a time. The memory port is synchronous: the core drives an address, and the matching read byte comes back on `mem_rdata` in the following cycle. A write is one cycle with the write strobe high.

The instruction set is fixed and tiny:
- Two opcodes are unconditional jumps. Each is followed by two operand bytes that give the target address.
- One opcode loads the constant 3.
- One opcode adds 2.
- One opcode adds 1.
- One opcode writes the working register to a fixed data address and then clears it.
- One opcode stops the core.

Every other byte value is a one-byte no-operation.

Each instruction runs as a short multi-cycle sequence with one memory access per cycle. The core is used as a sequencing engine: a program is placed at address 0x0000, reset is released, and the results appear as writes at the store address. The `halted` output tells the surroundings when the program has finished.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_addr` is 0x0000, `mem_we` is 0 and `halted` is 0. The working register resets to 0x00.
- R2: A one-byte instruction takes exactly 3 clock cycles: fetch, decode, execute. The next fetch uses the following address. A program of n one-byte instructions followed by 0x3F raises `halted` 3·(n+1) cycles after reset release.
- R3: Opcode 0x15 sets the working register to 3.
- R4: Opcode 0x2E adds 2 to the working register, modulo 256.
- R5: Opcode 0x25 adds 1 to the working register, modulo 256.
- R6: Opcode 0xC0 performs one write cycle of the working register to address 0x0F00 and then leaves the register at 0x00.
- R7: Opcodes 0x2B and 0x24 read the next two bytes as a target address, high byte first, and continue fetching at that target. A jump takes 5 cycles.
- R8: After opcode 0x3F executes, `halted` stays high and `mem_addr` holds the address of the 0x3F byte. No further write occurs.
- R9: Any opcode outside the seven above has no effect on the working register and advances by one byte.
- R10: `mem_we` is high only during the execute cycle of 0x0F00 stores, with `mem_addr` equal to 0x0F00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory byte address for the current cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 8 | Byte read from the address driven in the previous cycle |
| halted | output | 1 | High once the stop opcode has executed |

## Verification
The bench builds the core with its default 8-bit data and 16-bit address widths and the default store address of 0x0F00. It backs the core with an 8K-byte memory model, and every program and jump target sits inside that window.

Because opcodes are a single byte, the bench can reach every byte value. All 249 undefined opcodes are swept as no-operations. The arithmetic sweep covers increment and add counts up to the point where the register wraps past 255. Thirty-two jump targets, using both jump opcodes, are checked by the written value and by the exact cycle count.

// File: rtl/acc_cpu_pkg.sv
// Package: shared widths, opcode values, instruction classes and sequencer
// states for the accumulator core. Assumes byte-wide opcodes and data.
package acc_cpu_pkg;

    localparam int WORD_W = 8;
    localparam int ADDR_W = 2 * WORD_W;

    localparam logic [WORD_W-1:0] OPC_JUMP_A = 8'h2B;
    localparam logic [WORD_W-1:0] OPC_JUMP_B = 8'h24;
    localparam logic [WORD_W-1:0] OPC_LOAD3  = 8'h15;
    localparam logic [WORD_W-1:0] OPC_ADD2   = 8'h2E;
    localparam logic [WORD_W-1:0] OPC_INC    = 8'h25;
    localparam logic [WORD_W-1:0] OPC_STCLR  = 8'hC0;
    localparam logic [WORD_W-1:0] OPC_STOP   = 8'h3F;

    localparam logic [WORD_W-1:0] LOAD_CONST = 8'd3;
    localparam logic [WORD_W-1:0] ADD_CONST  = 8'd2;

    typedef enum logic [2:0] {
        CLS_NOP,
        CLS_JUMP,
        CLS_LOAD,
        CLS_ADD,
        CLS_INC,
        CLS_STORE,
        CLS_STOP
    } op_class_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPHI,
        ST_OPLO,
        ST_JUMP,
        ST_EXEC,
        ST_HALT
    } seq_state_t;

endpackage

// File: rtl/acc_cpu_decode.sv
// Module: acc_cpu_decode
// Maps a raw opcode byte onto an instruction class. Purely combinational.
// Assumes any byte not listed is treated as a one-byte no-operation.
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [WORD_W-1:0] opcode,
    output op_class_t         op_class
);

    // Classify the opcode byte
    always_comb begin
        unique case (opcode)
            OPC_JUMP_A, OPC_JUMP_B: op_class = CLS_JUMP;
            OPC_LOAD3:              op_class = CLS_LOAD;
            OPC_ADD2:               op_class = CLS_ADD;
            OPC_INC:                op_class = CLS_INC;
            OPC_STCLR:              op_class = CLS_STORE;
            OPC_STOP:               op_class = CLS_STOP;
            default:                op_class = CLS_NOP;
        endcase
    end

endmodule

// File: rtl/acc_cpu_acc.sv
// Module: acc_cpu_acc
// Holds the working register and applies the execute-cycle update.
// Assumes exec_en is high for exactly one cycle per instruction.
// Arithmetic wraps modulo 2**WORD_W.
module acc_cpu_acc
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  op_class_t         op_class,
    output logic [WORD_W-1:0] acc
);

    logic [WORD_W-1:0] acc_next;

    // Select the next register value for the executing class
    always_comb begin
        acc_next = acc;
        if (exec_en) begin
            unique case (op_class)
                CLS_LOAD:  acc_next = LOAD_CONST;
                CLS_ADD:   acc_next = acc + ADD_CONST;
                CLS_INC:   acc_next = acc + WORD_W'(1);
                CLS_STORE: acc_next = '0;
                default:   acc_next = acc;
            endcase
        end
    end

    // Register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= acc_next;
    end

    // R6
    store_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_class == CLS_STORE) |=> (acc == '0));

    // R4
    add_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_class == CLS_ADD) |=> (acc == WORD_W'($past(acc) + ADD_CONST)));

    // R9
    nop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_class == CLS_NOP) |=> $stable(acc));

endmodule

// File: rtl/acc_cpu_pc.sv
// Module: acc_cpu_pc
// Program counter. It steps by one on inc_en and loads a target on load_en.
// Assumes inc_en and load_en are never high together.
module acc_cpu_pc
    import acc_cpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_en,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] pc
);

    // Counter register with step and load
    always_ff @(posedge clk) begin
        if (!rst_n)       pc <= RESET_PC;
        else if (load_en) pc <= load_val;
        else if (inc_en)  pc <= pc + ADDR_W'(1);
    end

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !load_en) |=> (pc == ADDR_W'($past(pc) + 1)));

    // R7
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (pc == $past(load_val)));

endmodule

// File: rtl/acc_cpu_seq.sv
// Module: acc_cpu_seq
// Fetch/decode/execute sequencer. It issues one memory access per cycle
// and captures the high operand byte of a jump.
// Assumes read data arrives one cycle after its address.
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rdata,
    input  op_class_t         rd_class,
    output seq_state_t        state,
    output op_class_t         cur_class,
    output logic [WORD_W-1:0] tgt_hi,
    output logic              pc_inc,
    output logic              pc_load,
    output logic              exec_en
);

    // State progression and instruction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_FETCH;
            cur_class <= CLS_NOP;
            tgt_hi    <= '0;
        end else begin
            unique case (state)
                ST_FETCH:  state <= ST_DECODE;
                ST_DECODE: begin
                    cur_class <= rd_class;
                    state     <= (rd_class == CLS_JUMP) ? ST_OPHI : ST_EXEC;
                end
                ST_OPHI:   state <= ST_OPLO;
                ST_OPLO: begin
                    tgt_hi <= rdata;
                    state  <= ST_JUMP;
                end
                ST_JUMP:   state <= ST_FETCH;
                ST_EXEC:   state <= (cur_class == CLS_STOP) ? ST_HALT : ST_FETCH;
                ST_HALT:   state <= ST_HALT;
                default:   state <= ST_FETCH;
            endcase
        end
    end

    // Control strobes derived from the current state
    always_comb begin
        exec_en = (state == ST_EXEC);
        pc_inc  = exec_en && (cur_class != CLS_STOP);
        pc_load = (state == ST_JUMP);
    end

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_DECODE));

    // R7
    jump_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPHI) |=> (state == ST_OPLO));

endmodule

// File: rtl/acc_cpu_core.sv
// Module: acc_cpu_core
// Top of the accumulator processor. It ties the decoder, sequencer, program
// counter and working register together and selects the memory address.
// Assumes a synchronous memory with one cycle of read latency.
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STORE_ADDR = 16'h0F00,
    parameter logic [ADDR_W-1:0] BOOT_ADDR  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted
);

    op_class_t         rd_class;
    op_class_t         cur_class;
    seq_state_t        state;
    logic [WORD_W-1:0] tgt_hi;
    logic              pc_inc;
    logic              pc_load;
    logic              exec_en;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] acc;

    acc_cpu_decode u_decode (
        .opcode   (mem_rdata),
        .op_class (rd_class)
    );

    acc_cpu_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdata     (mem_rdata),
        .rd_class  (rd_class),
        .state     (state),
        .cur_class (cur_class),
        .tgt_hi    (tgt_hi),
        .pc_inc    (pc_inc),
        .pc_load   (pc_load),
        .exec_en   (exec_en)
    );

    acc_cpu_pc #(.RESET_PC(BOOT_ADDR)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (pc_inc),
        .load_en  (pc_load),
        .load_val ({tgt_hi, mem_rdata}),
        .pc       (pc)
    );

    acc_cpu_acc u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_en  (exec_en),
        .op_class (cur_class),
        .acc      (acc)
    );

    // Memory address, write strobe and status
    always_comb begin
        mem_we    = exec_en && (cur_class == CLS_STORE);
        mem_wdata = acc;
        halted    = (state == ST_HALT);
        unique case (state)
            ST_OPHI: mem_addr = pc + ADDR_W'(1);
            ST_OPLO: mem_addr = pc + ADDR_W'(2);
            default: mem_addr = mem_we ? STORE_ADDR : pc;
        endcase
    end

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(mem_addr) && !mem_we));

    // R10
    store_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == STORE_ADDR));

    // R10
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic        halted;

    logic [7:0]  mem [0:8191];
    logic [7:0]  wr_val [0:15];
    logic [15:0] wr_adr [0:15];
    int          wr_cnt;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #5 clk = ~clk;

    acc_cpu_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // Synchronous memory model: program bytes only, writes go to a log
    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr[12:0]];
        if (!rst_n) wr_cnt <= 0;
        else if (mem_we) begin
            if (wr_cnt < 16) begin
                wr_val[wr_cnt] <= mem_wdata;
                wr_adr[wr_cnt] <= mem_addr;
            end
            wr_cnt <= wr_cnt + 1;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    endtask

    // Reset, release at a falling edge, count rising edges until halted
    task automatic run_prog(output int edges);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        edges = 0;
        while (!halted && edges < 3000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
    endtask

    initial begin
        int e;
        int pos;
        int exp_v;
        int ok;
        int t;
        logic [7:0] opc;

        // R1 reset state
        clear_mem();
        mem[0] = 8'h25; mem[1] = 8'hC0; mem[2] = 8'h3F;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 addr in reset", {16'h0, mem_addr}, 32'h0);
        chk("R1 we in reset", {31'h0, mem_we}, 32'h0);
        rst_n = 1'b1;
        chk("R1 addr after release", {16'h0, mem_addr}, 32'h0);
        chk("R1 halted after release", {31'h0, halted}, 32'h0);
        e = 0;
        while (!halted && e < 3000) begin @(posedge clk); e++; @(negedge clk); end
        chk("R1 reset register value +1", {24'h0, wr_val[0]}, 32'd1);
        chk("R2 cycles for 2 ops + stop", e, 32'd9);

        // R3 R4 R5 R6 R10 arithmetic sweep with wrap
        for (int a = 0; a < 128; a++) begin
            int b;
            b = a % 5;
            clear_mem();
            pos = 0;
            mem[pos] = 8'h15; pos++;
            for (int k = 0; k < a; k++) begin mem[pos] = 8'h2E; pos++; end
            for (int k = 0; k < b; k++) begin mem[pos] = 8'h25; pos++; end
            mem[pos] = 8'hC0; mem[pos+1] = 8'hC0; mem[pos+2] = 8'h3F;
            run_prog(e);
            exp_v = (3 + 2 * a + b) % 256;
            chk("R3 R4 R5 stored sum", {24'h0, wr_val[0]}, exp_v);
            chk("R6 cleared after store", {24'h0, wr_val[1]}, 32'h0);
            chk("R10 write count", wr_cnt, 32'd2);
            chk("R10 write address", {16'h0, wr_adr[0]}, 32'h0F00);
            chk("R2 cycle count", e, 3 * (a + b + 4));
        end

        // R7 jump targets, both opcodes; R8 halt hold
        for (int i = 0; i < 32; i++) begin
            clear_mem();
            t = 16 + i * 251;
            mem[0] = (i % 2 == 0) ? 8'h2B : 8'h24;
            mem[1] = t[15:8];
            mem[2] = t[7:0];
            mem[3] = 8'hC0;
            mem[t] = 8'h15; mem[t+1] = 8'hC0; mem[t+2] = 8'h3F;
            run_prog(e);
            chk("R7 value at target", {24'h0, wr_val[0]}, 32'd3);
            chk("R7 write count", wr_cnt, 32'd1);
            chk("R7 jump cycles", e, 32'd14);
            ok = 1;
            for (int k = 0; k < 20; k++) begin
                if (mem_addr !== t[15:0] + 16'd2 || mem_we !== 1'b0 || halted !== 1'b1) ok = 0;
                @(posedge clk); @(negedge clk);
            end
            chk("R8 halt holds", ok, 32'd1);
            chk("R8 no writes after halt", wr_cnt, 32'd1);
        end

        // R9 every undefined opcode is a one-byte no-operation
        for (int v = 0; v < 256; v++) begin
            opc = v[7:0];
            if (opc != 8'h15 && opc != 8'h2E && opc != 8'h25 && opc != 8'hC0 &&
                opc != 8'h3F && opc != 8'h2B && opc != 8'h24) begin
                clear_mem();
                mem[0] = 8'h15; mem[1] = opc; mem[2] = 8'h25; mem[3] = 8'hC0; mem[4] = 8'h3F;
                run_prog(e);
                chk("R9 nop value", {24'h0, wr_val[0]}, 32'd4);
                chk("R9 nop cycles", e, 32'd15);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule